// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit forms the 16-bit address of a memory operand for an 8-bit processor core. On each `start` pulse it takes four inputs: an addressing-mode code, the one or two operand bytes that follow the opcode, the two index registers and the program counter. One clock later it presents the resulting address on a registered output, together with a `valid` strobe. Direct, extended, indexed and relative forms each produce an address. Immediate and inherent forms need no memory access, so the unit marks them with a flag.

The unit does not fetch, decode or access memory. It does not judge branch conditions either. For relative mode the branch logic supplies a `taken` bit, and the `pc` input already points at the next sequential instruction. All arithmetic goes through a single shared adder. Its two inputs are a base and an offset that a small selector picks for each mode.

Top module: `ea_gen_unit`

## Requirements
- R1: `valid` is high in exactly the cycle after a cycle in which `start` was high, and low otherwise.
- R2: Mode code 2 (direct) yields `ea = {8'h00, op_lo}` with `no_addr` low. `op_hi` has no effect.
- R3: Mode code 3 (extended) yields `ea = {op_hi, op_lo}`, with `op_hi` as the high byte and `no_addr` low.
- R4: Mode code 4 (indexed) adds `op_lo`, zero-extended (0 to 255), to `ix` when `idx_sel` is 0 or to `iy` when `idx_sel` is 1. The sum wraps modulo 2^16.
- R5: In indexed mode an offset of zero (an instruction with no offset) yields the selected index register unchanged.
- R6: Mode code 5 (relative) with `taken` high yields `pc` plus `op_lo` sign-extended (-128 to +127), wrapping modulo 2^16.
- R7: Mode code 5 with `taken` low yields `ea = pc`, whatever `op_lo` holds.
- R8: Mode codes 0 (immediate) and 1 (inherent), and the unused codes 6 and 7, set `no_addr` high and `ea` to 0x0000.
- R9: While `start` is low, `ea` and `no_addr` keep their last values whatever the other inputs do.
- R10: Synchronous active-high reset clears `ea`, `no_addr` and `valid` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request: capture an address this cycle |
| mode | input | 3 | Addressing-mode code |
| op_hi | input | 8 | First operand byte (high address byte in extended mode) |
| op_lo | input | 8 | Second operand byte, or offset / low address byte |
| ix | input | 16 | Index register X |
| iy | input | 16 | Index register Y |
| pc | input | 16 | Address of the next sequential instruction |
| idx_sel | input | 1 | Indexed base select: 0 = X, 1 = Y |
| taken | input | 1 | Branch condition is true (relative mode) |
| ea | output | 16 | Registered effective address |
| no_addr | output | 1 | Registered flag: the mode needs no memory address |
| valid | output | 1 | Result strobe, one cycle after `start` |

## Verification
The assertions assume that the inputs are steady and defined around the rising edge on which `start` is high, and that `rst` is held long enough to cover one edge. They also assume that `start` stays low during reset, so that no attempt starts from an undefined request. The bench drives every input on the falling edge and keeps `start` low through reset. It then issues requests both back to back and separated by idle gaps, in which it scrambles the mode and operand inputs. This shows that nothing but a request can move the outputs.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

  typedef logic [2:0] mode_t;

  localparam mode_t MODE_IMM = 3'd0;
  localparam mode_t MODE_INH = 3'd1;
  localparam mode_t MODE_DIR = 3'd2;
  localparam mode_t MODE_EXT = 3'd3;
  localparam mode_t MODE_IDX = 3'd4;
  localparam mode_t MODE_REL = 3'd5;

endpackage

// File: rtl/eagu_operand_sel.sv
module eagu_operand_sel #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic [2:0]        mode,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] iy,
  input  logic [ADDR_W-1:0] pc,
  input  logic              idx_sel,
  input  logic              taken,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] offset,
  output logic              no_addr
);
  import eagu_pkg::*;

  localparam int PAD_W  = ADDR_W - BYTE_W;
  localparam int PAIR_W = 2 * BYTE_W;

  logic [ADDR_W-1:0] lo_zext;
  logic [ADDR_W-1:0] lo_sext;
  logic [ADDR_W-1:0] pair_addr;
  logic [ADDR_W-1:0] idx_base;

  // Offset byte widened two ways: unsigned for page/index, signed for branches
  assign lo_zext = {{PAD_W{1'b0}}, op_lo};
  assign lo_sext = {{PAD_W{op_lo[BYTE_W-1]}}, op_lo};

  // Both operand bytes as one address; width adapted by parameter
  generate
    if (ADDR_W > PAIR_W) begin : g_pair_pad
      assign pair_addr = {{(ADDR_W-PAIR_W){1'b0}}, op_hi, op_lo};
    end else if (ADDR_W == PAIR_W) begin : g_pair_exact
      assign pair_addr = {op_hi, op_lo};
    end else begin : g_pair_trim
      logic [PAIR_W-1:0] pair_full;
      assign pair_full = {op_hi, op_lo};
      assign pair_addr = pair_full[ADDR_W-1:0];
    end
  endgenerate

  assign idx_base = idx_sel ? iy : ix;

  always_comb begin
    base    = '0;
    offset  = '0;
    no_addr = 1'b0;
    unique case (mode)
      MODE_DIR: begin
        offset = lo_zext;
      end
      MODE_EXT: begin
        base = pair_addr;
      end
      MODE_IDX: begin
        base   = idx_base;
        offset = lo_zext;
      end
      MODE_REL: begin
        base   = pc;
        offset = taken ? lo_sext : '0;
      end
      default: begin
        no_addr = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/eagu_adder.sv
module eagu_adder #(
  parameter int W     = 16,
  parameter bit SPLIT = 1'b1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum
);

  localparam int LO_W = W / 2;
  localparam int HI_W = W - LO_W;

  generate
    if (SPLIT && W >= 4) begin : g_csel
      logic [LO_W:0]   lo_sum;
      logic [HI_W-1:0] hi_c0;
      logic [HI_W-1:0] hi_c1;

      assign lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b[LO_W-1:0]};
      assign hi_c0  = a[W-1:LO_W] + b[W-1:LO_W];
      assign hi_c1  = a[W-1:LO_W] + b[W-1:LO_W] + {{(HI_W-1){1'b0}}, 1'b1};
      assign sum    = {(lo_sum[LO_W] ? hi_c1 : hi_c0), lo_sum[LO_W-1:0]};
    end else begin : g_ripple
      assign sum = a + b;
    end
  endgenerate

endmodule

// File: rtl/ea_gen_unit.sv
module ea_gen_unit #(
  parameter int ADDR_W    = 16,
  parameter int BYTE_W    = 8,
  parameter bit SPLIT_ADD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [BYTE_W-1:0] op_hi,
  input  logic [BYTE_W-1:0] op_lo,
  input  logic [ADDR_W-1:0] ix,
  input  logic [ADDR_W-1:0] iy,
  input  logic [ADDR_W-1:0] pc,
  input  logic              idx_sel,
  input  logic              taken,
  output logic [ADDR_W-1:0] ea,
  output logic              no_addr,
  output logic              valid
);
  import eagu_pkg::*;

  localparam int PAD_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] sum;
  logic              no_addr_c;

  eagu_operand_sel #(
    .ADDR_W (ADDR_W),
    .BYTE_W (BYTE_W)
  ) u_sel (
    .mode    (mode),
    .op_hi   (op_hi),
    .op_lo   (op_lo),
    .ix      (ix),
    .iy      (iy),
    .pc      (pc),
    .idx_sel (idx_sel),
    .taken   (taken),
    .base    (base),
    .offset  (offset),
    .no_addr (no_addr_c)
  );

  eagu_adder #(
    .W     (ADDR_W),
    .SPLIT (SPLIT_ADD)
  ) u_add (
    .a   (base),
    .b   (offset),
    .sum (sum)
  );

  // Output stage: capture only on a request, otherwise hold
  always_ff @(posedge clk) begin
    if (rst) begin
      ea      <= '0;
      no_addr <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= start;
      if (start) begin
        ea      <= no_addr_c ? '0 : sum;
        no_addr <= no_addr_c;
      end
    end
  end

  // ---------------------------------------------------------------
  // Checks on the output stage
  // ---------------------------------------------------------------
  assert_valid_follows_start_R1: assert property (@(posedge clk) disable iff (rst)
    valid == $past(start));

  assert_direct_page_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (start && mode == MODE_DIR) |=>
      (ea == {{PAD_W{1'b0}}, $past(op_lo)}) && !no_addr);

  assert_extended_bytes_R3: assert property (@(posedge clk) disable iff (rst)
    (start && mode == MODE_EXT) |=>
      (ea[BYTE_W-1:0] == $past(op_lo)) && !no_addr);

  assert_index_zero_offset_R5: assert property (@(posedge clk) disable iff (rst)
    (start && mode == MODE_IDX && op_lo == '0) |=>
      (ea == ($past(idx_sel) ? $past(iy) : $past(ix))));

  assert_rel_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (start && mode == MODE_REL && taken) |=>
      (ea == ADDR_W'($past(pc) + {{PAD_W{$past(op_lo[BYTE_W-1])}}, $past(op_lo)})));

  assert_rel_not_taken_R7: assert property (@(posedge clk) disable iff (rst)
    (start && mode == MODE_REL && !taken) |=> (ea == $past(pc)) && !no_addr);

  assert_no_addr_modes_R8: assert property (@(posedge clk) disable iff (rst)
    (start && (mode == MODE_IMM || mode == MODE_INH || mode > MODE_REL)) |=>
      no_addr && (ea == '0));

  assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(ea) && $stable(no_addr));

  assert_reset_clears_R10: assert property (@(posedge clk)
    $past(rst) |-> (!valid && !no_addr && ea == '0));

endmodule

// File: tb/ea_gen_unit_bench.sv
`timescale 1ns/1ps
module ea_gen_unit_bench;

  localparam int WATCHDOG_NS = 200000;

  typedef struct {
    logic [15:0] ea;
    logic        na;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [7:0]  op_hi = '0;
  logic [7:0]  op_lo = '0;
  logic [15:0] ix = '0;
  logic [15:0] iy = '0;
  logic [15:0] pc = '0;
  logic        idx_sel = 1'b0;
  logic        taken = 1'b0;
  logic [15:0] ea;
  logic        no_addr;
  logic        valid;

  int   checks = 0;
  int   fails  = 0;
  exp_t sb_q[$];
  exp_t last_exp;
  bit   mon_on = 1'b0;
  bit   done   = 1'b0;

  always #2.5 clk = ~clk;

  ea_gen_unit u_ea_gen_unit (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .mode    (mode),
    .op_hi   (op_hi),
    .op_lo   (op_lo),
    .ix      (ix),
    .iy      (iy),
    .pc      (pc),
    .idx_sel (idx_sel),
    .taken   (taken),
    .ea      (ea),
    .no_addr (no_addr),
    .valid   (valid)
  );

  // Reference model written from the requirements
  function automatic exp_t model(input logic [2:0] m, input logic [7:0] hi,
                                 input logic [7:0] lo, input logic [15:0] x,
                                 input logic [15:0] y, input logic [15:0] p,
                                 input logic sel, input logic tk);
    exp_t e;
    int   s;
    e.na = 1'b0;
    case (m)
      3'd2: begin e.ea = {8'h00, lo}; e.tag = "R2"; end
      3'd3: begin e.ea = {hi, lo}; e.tag = "R3"; end
      3'd4: begin
        e.ea  = 16'((sel ? int'(y) : int'(x)) + int'(lo));
        e.tag = (lo == 8'h00) ? "R5" : "R4";
      end
      3'd5: begin
        if (tk) begin
          s     = (lo >= 8'd128) ? int'(lo) - 256 : int'(lo);
          e.ea  = 16'((int'(p) + s + 65536) % 65536);
          e.tag = "R6";
        end else begin
          e.ea  = p;
          e.tag = "R7";
        end
      end
      default: begin e.ea = 16'h0000; e.na = 1'b1; e.tag = "R8"; end
    endcase
    return e;
  endfunction

  task automatic send(input logic [2:0] m, input logic [7:0] hi, input logic [7:0] lo,
                      input logic [15:0] x, input logic [15:0] y, input logic [15:0] p,
                      input logic sel, input logic tk);
    @(negedge clk);
    mode = m; op_hi = hi; op_lo = lo; ix = x; iy = y; pc = p;
    idx_sel = sel; taken = tk; start = 1'b1;
    last_exp = model(m, hi, lo, x, y, p, sel, tk);
    sb_q.push_back(last_exp);
  endtask

  // Idle cycles with scrambled inputs; outputs must hold (R9)
  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      start = 1'b0;
      mode = 3'($urandom); op_hi = 8'($urandom); op_lo = 8'($urandom);
      ix = 16'($urandom); iy = 16'($urandom); pc = 16'($urandom);
      idx_sel = 1'($urandom); taken = 1'($urandom);
    end
    wait (sb_q.size() == 0);
    @(negedge clk);
    checks++;
    if (ea !== last_exp.ea || no_addr !== last_exp.na || valid !== 1'b0) begin
      fails++;
      $display("FAIL R9: idle ea=%h na=%b valid=%b expected ea=%h na=%b valid=0",
               ea, no_addr, valid, last_exp.ea, last_exp.na);
    end
  endtask

  // Monitor: compares each strobed result with the scoreboard head (R1)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        if (valid) begin
          checks++;
          if (sb_q.size() == 0) begin
            fails++;
            $display("FAIL R1: valid=1 with nothing pending, expected valid=0");
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            if (ea !== e.ea || no_addr !== e.na) begin
              fails++;
              $display("FAIL %s: ea=%h na=%b expected ea=%h na=%b",
                       e.tag, ea, no_addr, e.ea, e.na);
            end
          end
        end else if (sb_q.size() != 0 && !start) begin
          checks++;
          fails++;
          $display("FAIL R1: valid=0 with result pending, expected valid=1");
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(WATCHDOG_NS);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    checks++;
    if (ea !== 16'h0000 || no_addr !== 1'b0 || valid !== 1'b0) begin
      fails++;
      $display("FAIL R10: ea=%h na=%b valid=%b expected 0000 0 0", ea, no_addr, valid);
    end
    mon_on = 1'b1;

    // R2: direct, high operand byte ignored
    send(3'd2, 8'hAB, 8'h21, 16'h1111, 16'h2222, 16'h3333, 1'b0, 1'b1);
    send(3'd2, 8'hFF, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 1'b1, 1'b0);
    idle_check(2);
    // R3: extended
    send(3'd3, 8'h80, 8'h08, 16'h1234, 16'h5678, 16'h9ABC, 1'b0, 1'b0);
    send(3'd3, 8'hFF, 8'hFF, 16'h0000, 16'h0000, 16'h0000, 1'b0, 1'b0);
    send(3'd3, 8'h00, 8'h01, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1'b1, 1'b1);
    idle_check(3);
    // R4/R5: indexed
    send(3'd4, 8'h00, 8'h10, 16'h8000, 16'h4000, 16'h0000, 1'b0, 1'b0);
    send(3'd4, 8'h00, 8'h07, 16'h9000, 16'hC000, 16'h0000, 1'b1, 1'b0);
    send(3'd4, 8'h55, 8'hFF, 16'h1000, 16'h2000, 16'h0000, 1'b0, 1'b1);
    send(3'd4, 8'h00, 8'h20, 16'hFFF0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    send(3'd4, 8'h00, 8'h00, 16'hBEEF, 16'hCAFE, 16'h0000, 1'b0, 1'b0);
    send(3'd4, 8'h00, 8'h00, 16'hBEEF, 16'hCAFE, 16'h0000, 1'b1, 1'b0);
    idle_check(1);
    // R6/R7: relative
    send(3'd5, 8'h00, 8'h05, 16'h0000, 16'h0000, 16'h004A, 1'b0, 1'b1);
    send(3'd5, 8'h00, 8'h80, 16'h0000, 16'h0000, 16'h0010, 1'b0, 1'b1);
    send(3'd5, 8'h00, 8'h7F, 16'h0000, 16'h0000, 16'hFFF0, 1'b0, 1'b1);
    send(3'd5, 8'h00, 8'hFE, 16'h0000, 16'h0000, 16'h2000, 1'b1, 1'b1);
    send(3'd5, 8'hAA, 8'h80, 16'h0000, 16'h0000, 16'h1234, 1'b0, 1'b0);
    send(3'd5, 8'h00, 8'h7F, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b0);
    idle_check(2);
    // R8: no-address codes
    send(3'd0, 8'h12, 8'h34, 16'h5555, 16'h6666, 16'h7777, 1'b0, 1'b1);
    send(3'd1, 8'h12, 8'h34, 16'h5555, 16'h6666, 16'h7777, 1'b1, 1'b1);
    send(3'd6, 8'h12, 8'h34, 16'h5555, 16'h6666, 16'h7777, 1'b0, 1'b0);
    send(3'd7, 8'h12, 8'h34, 16'h5555, 16'h6666, 16'h7777, 1'b1, 1'b0);
    idle_check(2);
    // Back-to-back mixed stream
    for (int i = 0; i < 60; i++) begin
      send(3'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
           16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom));
      if (i % 15 == 14) idle_check(1 + i % 3);
    end
    idle_check(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule